// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable integer. It emits one single-cycle output pulse per output period. Two numbers set the ratio: a main count M (9 bits) and a swallow count A (4 bits). In swallow mode a prescaler stage counts ten or eleven input cycles per sub-cycle. A main counter counts M+1 prescaler sub-cycles. During the first A sub-cycles of each period the prescaler runs at modulus eleven, so the period is 10*(M+1)+A input cycles.

An active-low prescaler enable selects between the two paths. When the enable is high, the prescaler is bypassed and held at zero, A has no effect, and the main counter divides the input by M+1 directly. A narrow-range flag forces the two top bits of M to zero, which limits M to 1..127. Settings are sampled only at the end of an output period, so a running period always completes with the ratio it started with. A larger loop, such as a frequency synthesizer, uses the block as its feedback divider.

Top module: `swallow_divider`

## Requirements
- R1: With `pre_en_n` low, consecutive rising edges of `div_pulse` are exactly 10*(M+1)+A input cycles apart, for 1 <= M <= 511 and 0 <= A <= M+1.
- R2: Within one period the prescaler runs at modulus 11 for the first A sub-cycles and at modulus 10 for the rest. As a result, stepping A by one with M fixed lengthens the period by exactly one cycle.
- R3: With `pre_en_n` high, the period is M+1 input cycles whatever the value of `a_val`. M=1 gives the smallest ratio, 2.
- R4: While the bypass path is selected, the prescaler count is held at zero. The first swallow-mode period after leaving bypass has the exact R1 length.
- R5: With `narrow_m` high, bits 8 and 7 of `m_val` are treated as zero, so the effective M is `m_val[6:0]`.
- R6: A value of `a_val` above M+1 (after the R5 masking) is clamped to M+1.
- R7: `m_val`, `a_val`, `pre_en_n` and `narrow_m` are sampled only at the clock edge that ends a period. A change during a period never alters that period's length, and it governs the following period.
- R8: `div_pulse` is high for exactly one input cycle per period.
- R9: While `rst_n` is low (synchronous reset), `div_pulse` is low and the counters are zero. The first pulse after reset comes one full period after release, with the settings present at release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| m_val | input | 9 | Main count M |
| a_val | input | 4 | Swallow count A |
| pre_en_n | input | 1 | Low: prescaler path; high: bypass, divide by M+1 |
| narrow_m | input | 1 | High: force M bits 8 and 7 to zero |
| div_pulse | output | 1 | One-cycle pulse per output period |

## Verification
Any wrong internal state shows up as a change in the spacing of `div_pulse`. A prescaler stuck at one modulus, or a swallow compare off by one, shifts the period by at least one cycle at the very next pulse. A configuration register that loads mid-period gives a wrong length for the period in which the change lands. Leftover prescaler state after bypass corrupts the first swallow-mode period. Measuring every pulse-to-pulse interval against the formula therefore exposes each of these faults within one output period of the fault, at most about 5,100 input cycles.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

   typedef enum logic {
      PATH_SWALLOW = 1'b0,
      PATH_DIRECT  = 1'b1
   } path_e;

   function automatic int max_int(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/swdiv_cfg.sv
// Settings register: applies the narrow-range mask and the swallow clamp,
// then captures the result at period boundaries only.
module swdiv_cfg #(
   parameter int M_W = 9,
   parameter int A_W = 4,
   parameter int RB  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [M_W-1:0]    m_in,
   input  logic [A_W-1:0]    a_in,
   input  logic              direct_in,
   input  logic              narrow_in,
   output logic [M_W-1:0]    m_q,
   output logic [A_W-1:0]    a_q,
   output swdiv_pkg::path_e  path_q,
   output logic              narrow_q
);
   localparam int CW = swdiv_pkg::max_int(M_W + 1, A_W) + 1;

   logic [M_W-1:0] m_eff;
   logic [CW-1:0]  lim;
   logic [CW-1:0]  a_wide;
   logic [A_W-1:0] a_eff;

   generate
      if (RB == 0) begin : g_nomask
         assign m_eff = m_in;
      end else begin : g_mask
         localparam logic [M_W-1:0] KEEP = {{RB{1'b0}}, {(M_W-RB){1'b1}}};
         assign m_eff = narrow_in ? (m_in & KEEP) : m_in;
      end
   endgenerate

   assign lim    = CW'(m_eff) + CW'(1);
   assign a_wide = CW'(a_in);
   assign a_eff  = (a_wide > lim) ? A_W'(lim) : a_in;

   // Loaded continuously during reset so the first period uses live inputs.
   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         m_q      <= m_eff;
         a_q      <= a_eff;
         path_q   <= direct_in ? swdiv_pkg::PATH_DIRECT : swdiv_pkg::PATH_SWALLOW;
         narrow_q <= narrow_in;
      end
   end
endmodule

// File: rtl/swdiv_prescaler.sv
// Dual-modulus stage: PRE_LO or PRE_LO+1 input cycles per sub-cycle.
module swdiv_prescaler #(
   parameter int PRE_LO = 10,
   parameter int PW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          swallow,
   output logic [PW-1:0] pcnt,
   output logic          tick
);
   logic [PW-1:0] last;

   assign last = swallow ? PW'(PRE_LO) : PW'(PRE_LO - 1);
   assign tick = hold | (pcnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n || hold || tick) pcnt <= '0;
      else                        pcnt <= pcnt + 1'b1;
   end
endmodule

// File: rtl/swdiv_main_ctr.sv
// Main counter: counts sub-cycles 0..M and selects the modulus.
module swdiv_main_ctr #(
   parameter int M_W = 9,
   parameter int A_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [M_W-1:0] m_lim,
   input  logic [A_W-1:0] a_lim,
   output logic [M_W-1:0] mcnt,
   output logic           swallow,
   output logic           wrap
);
   localparam int CW = swdiv_pkg::max_int(M_W, A_W) + 1;

   assign swallow = CW'(mcnt) < CW'(a_lim);
   assign wrap    = tick && (mcnt == m_lim);

   always_ff @(posedge clk) begin
      if (!rst_n || wrap) mcnt <= '0;
      else if (tick)      mcnt <= mcnt + 1'b1;
   end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
   parameter int M_W           = 9,
   parameter int A_W           = 4,
   parameter int PRE_LO        = 10,
   parameter int RESTRICT_BITS = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [M_W-1:0] m_val,
   input  logic [A_W-1:0] a_val,
   input  logic           pre_en_n,
   input  logic           narrow_m,
   output logic           div_pulse
);
   localparam int PW = $clog2(PRE_LO + 2);

   generate
      if (PRE_LO < 2) begin : g_bad_mod
         $error("swallow_divider: PRE_LO must be at least 2");
      end
      if (RESTRICT_BITS < 0 || RESTRICT_BITS >= M_W) begin : g_bad_rb
         $error("swallow_divider: RESTRICT_BITS must lie in 0..M_W-1");
      end
      if (M_W < 2 || A_W < 1) begin : g_bad_w
         $error("swallow_divider: M_W >= 2 and A_W >= 1 required");
      end
   endgenerate

   logic [M_W-1:0]   cfg_m;
   logic [A_W-1:0]   cfg_a;
   swdiv_pkg::path_e cfg_path;
   logic             cfg_narrow;
   logic [PW-1:0]    pcnt;
   logic [M_W-1:0]   mcnt;
   logic             tick;
   logic             swallow;
   logic             wrap;
   logic             hold;

   assign hold = (cfg_path == swdiv_pkg::PATH_DIRECT);

   swdiv_cfg #(.M_W(M_W), .A_W(A_W), .RB(RESTRICT_BITS)) i_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wrap),
      .m_in     (m_val),
      .a_in     (a_val),
      .direct_in(pre_en_n),
      .narrow_in(narrow_m),
      .m_q      (cfg_m),
      .a_q      (cfg_a),
      .path_q   (cfg_path),
      .narrow_q (cfg_narrow)
   );

   swdiv_prescaler #(.PRE_LO(PRE_LO), .PW(PW)) i_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (hold),
      .swallow(swallow),
      .pcnt   (pcnt),
      .tick   (tick)
   );

   swdiv_main_ctr #(.M_W(M_W), .A_W(A_W)) i_main (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .m_lim  (cfg_m),
      .a_lim  (cfg_a),
      .mcnt   (mcnt),
      .swallow(swallow),
      .wrap   (wrap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) div_pulse <= 1'b0;
      else        div_pulse <= wrap;
   end
endmodule

// File: rtl/swdiv_checker.sv
module swdiv_checker #(
   parameter int M_W    = 9,
   parameter int A_W    = 4,
   parameter int PRE_LO = 10,
   parameter int RB     = 2,
   parameter int PW     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             div_pulse,
   input logic             wrap,
   input logic [PW-1:0]    pcnt,
   input logic [M_W-1:0]   mcnt,
   input logic [M_W-1:0]   cfg_m,
   input logic [A_W-1:0]   cfg_a,
   input swdiv_pkg::path_e cfg_path,
   input logic             cfg_narrow
);
   assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(mcnt) <= int'(cfg_m));

   assert_swallow_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(pcnt) == PRE_LO) |-> (int'(mcnt) < int'(cfg_a)));

   assert_bypass_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_path == swdiv_pkg::PATH_DIRECT) |-> (pcnt == '0));

   generate
      if (RB > 0) begin : g_mask_chk
         assert_masked_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_narrow |-> (cfg_m[M_W-1 -: RB] == '0));
      end
   endgenerate

   assert_clamped_swallow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cfg_a) <= int'(cfg_m) + 1);

   assert_frozen_settings_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> ($stable(cfg_m) && $stable(cfg_a) && $stable(cfg_path) && $stable(cfg_narrow)));

   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   assert_clean_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!div_pulse && mcnt == '0 && pcnt == '0));
endmodule

bind swallow_divider swdiv_checker #(
   .M_W(M_W), .A_W(A_W), .PRE_LO(PRE_LO), .RB(RESTRICT_BITS), .PW(PW)
) i_swdiv_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .div_pulse (div_pulse),
   .wrap      (wrap),
   .pcnt      (pcnt),
   .mcnt      (mcnt),
   .cfg_m     (cfg_m),
   .cfg_a     (cfg_a),
   .cfg_path  (cfg_path),
   .cfg_narrow(cfg_narrow)
);

// File: tb/test_swallow_divider.sv
`timescale 1ns/1ps
module test_swallow_divider;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] m_val = 9'd3;
   logic [3:0] a_val = 4'd2;
   logic       pre_en_n = 1'b0;
   logic       narrow_m = 1'b0;
   logic       div_pulse;

   int    vectors = 0;
   int    miscompares = 0;
   int    cur_exp;
   string cur_tag;
   string pend_tag = "R9";
   bit    hung = 1'b0;
   bit    finished = 1'b0;

   always #2 clk = ~clk;

   swallow_divider i_swallow_divider (
      .clk(clk), .rst_n(rst_n), .m_val(m_val), .a_val(a_val),
      .pre_en_n(pre_en_n), .narrow_m(narrow_m), .div_pulse(div_pulse)
   );

   function automatic int exp_period(input int m, input int a, input bit byp, input bit nar);
      int me, ae;
      me = nar ? (m & 127) : m;
      ae = (a > me + 1) ? me + 1 : a;
      return byp ? (me + 1) : (10 * (me + 1) + ae);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic prog(input int m, input int a, input bit byp, input bit nar, input string tag);
      m_val    = 9'(m);
      a_val    = 4'(a);
      pre_en_n = byp;
      narrow_m = nar;
      pend_tag = tag;
   endtask

   // Waits for the next pulse, measures the interval, optionally
   // reprograms the inputs in the middle of the running period.
   task automatic next_pulse(input int chg_at, input int nm, input int na,
                             input bit nb, input bit nr, input string ntag);
      int  cnt = 0;
      bit  done = 1'b0;
      while (!done && !hung) begin
         @(negedge clk);
         cnt++;
         if (cnt == chg_at) prog(nm, na, nb, nr, ntag);
         if (cnt == 1) chk(div_pulse == 1'b0, "R8 pulse width", int'(div_pulse), 0);
         if (div_pulse) begin
            chk(cnt == cur_exp, cur_tag, cnt, cur_exp);
            cur_exp = exp_period(int'(m_val), int'(a_val), pre_en_n, narrow_m);
            cur_tag = pend_tag;
            done = 1'b1;
         end else if (cnt > 6000) begin
            chk(1'b0, {cur_tag, " watchdog"}, cnt, cur_exp);
            hung = 1'b1;
         end
      end
   endtask

   task automatic step(input int m, input int a, input bit byp, input bit nar, input string tag);
      prog(m, a, byp, nar, tag);
      next_pulse(-1, 0, 0, 1'b0, 1'b0, "");
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "R1 global watchdog", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int rm, ra, rb, rr, rc;
      void'($urandom(32'd20240611));
      // R9: output quiet during reset
      repeat (4) begin
         @(negedge clk);
         chk(div_pulse == 1'b0, "R9 reset", int'(div_pulse), 0);
      end
      cur_exp = exp_period(3, 2, 1'b0, 1'b0);   // 42, first period after release
      cur_tag = "R9 first period";
      rst_n = 1'b1;
      next_pulse(-1, 0, 0, 1'b0, 1'b0, "");
      // directed corners (each applies to the period after next)
      step(5, 3, 1'b0, 1'b0, "R1 M5 A3");
      step(20, 0, 1'b0, 1'b0, "R1 A zero");
      step(4, 5, 1'b0, 1'b0, "R1 A equals M+1");
      step(1, 9, 1'b0, 1'b0, "R6 clamp M1");
      step(2, 15, 1'b0, 1'b0, "R6 clamp M2");
      step(1, 0, 1'b0, 1'b0, "R3 min ratio swallow");
      step(1, 5, 1'b1, 1'b0, "R3 min ratio bypass");
      step(9, 7, 1'b1, 1'b0, "R3 bypass A7");
      step(9, 0, 1'b1, 1'b0, "R3 bypass A0");
      step(9, 7, 1'b0, 1'b0, "R4 after bypass");
      step(387, 2, 1'b0, 1'b1, "R5 narrow");
      step(387, 2, 1'b0, 1'b0, "R5 wide");
      step(511, 15, 1'b0, 1'b1, "R5 narrow max");
      step(389, 3, 1'b1, 1'b1, "R5 narrow bypass");
      for (int a = 0; a <= 7; a++) step(6, a, 1'b0, 1'b0, "R2 A sweep");
      step(511, 15, 1'b0, 1'b0, "R1 max M");
      // random configurations changed at random points mid-period (R7)
      for (int i = 0; i < 30; i++) begin
         rm = ($urandom % 2) ? (1 + $urandom % 40) : (1 + $urandom % 511);
         ra = $urandom % 16;
         rb = (($urandom % 8) == 0) ? 1 : 0;
         rr = (($urandom % 4) == 0) ? 1 : 0;
         if (rr == 1 && (rm & 127) == 0) rm = rm | 1;
         rc = 1 + $urandom % (cur_exp - 1);
         next_pulse(rc, rm, ra, rb[0], rr[0],
                    (rb == 1) ? "R7 R3 random" :
                    (rr == 1 && rm > 127) ? "R7 R5 random" :
                    (ra > ((rr == 1 ? (rm & 127) : rm) + 1)) ? "R7 R6 random" : "R7 R1 random");
      end
      next_pulse(-1, 0, 0, 1'b0, 1'b0, "");
      next_pulse(-1, 0, 0, 1'b0, 1'b0, "");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule